// File: doc/BRIEF.md
# Rotate and Shift Unit with Flags

This block performs the single-bit rotate and shift operations of a small accumulator CPU on an 8-bit operand and produces the new flag byte. Seven operations are offered: two rotates that wrap the outgoing bit back in, two rotates that pass through the carry flag, a left shift that fills with zero, an arithmetic right shift that keeps the sign, and a logical right shift. The half-carry and subtract flags are always cleared and the carry takes the bit shifted out. A per-operation select decides whether the sign, zero and parity flags are recomputed from the result or passed through unchanged. The unchanged form is the fast accumulator form.

Two users share the same datapath. An accumulator port is purely combinational, and the caller chooses the flag-update select. A memory port runs a read-modify-write sequence after a start pulse: it reads the byte, computes the result, and writes it back. This port always updates sign, zero and parity. It counts every read and every write in separate wrapping counters.

Top module: `rotsh_top`

## Requirements
- R1: Op code 0 rotates left with bit 7 going to bit 0 and to carry. Op code 1 rotates right with bit 0 going to bit 7 and to carry.
- R2: Op code 2 shifts left, fills bit 0 with the incoming carry flag, and takes the new carry from the old bit 7. Op code 3 shifts right, fills bit 7 with the incoming carry, and takes the new carry from the old bit 0.
- R3: Op code 4 shifts left with a zero fill and takes carry from the old bit 7. Op code 6 shifts right with a zero fill and takes carry from the old bit 0.
- R4: Op code 5 shifts right, keeps the old bit 7 in bit 7, and takes carry from the old bit 0.
- R5: Op code 7 returns the operand unchanged and sets the carry to 0.
- R6: The flag byte has sign at bit 7, zero at 6, half-carry at 4, parity at 2, subtract at 1 and carry at 0. Half-carry and subtract are always cleared, carry is always rewritten, and bits 5 and 3 pass through.
- R7: With the update select at 1, sign equals result bit 7, zero is 1 exactly when the result is 0, and parity is 1 when the result has an even count of ones.
- R8: With the update select at 0, sign, zero and parity keep their incoming values.
- R9: A start seen while idle gives one read cycle at the latched address, then one write cycle of the computed result to the same address, then one cycle of done. The flags output then holds the result flags with sign, zero and parity always updated, and the carry input taken from the flags latched at start.
- R10: The read and write counters start at 0, each advances by exactly one per read or write cycle, and each wraps at its width.
- R11: A start that arrives while a sequence is in progress is ignored.
- R12: After reset the memory port is idle, with no read, write or done, both counters at 0, and the flags output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_data_i | input | 8 | Accumulator operand |
| acc_op_i | input | 3 | Accumulator op code |
| acc_flags_i | input | 8 | Accumulator incoming flag byte |
| acc_szp_i | input | 1 | 1: update sign, zero and parity |
| acc_data_o | output | 8 | Accumulator result |
| acc_flags_o | output | 8 | Accumulator new flag byte |
| mem_start_i | input | 1 | Start a read-modify-write |
| mem_op_i | input | 3 | Memory op code, latched at start |
| mem_addr_i | input | AW | Memory address, latched at start |
| mem_flags_i | input | 8 | Incoming flag byte, latched at start |
| mem_rdata_i | input | 8 | Read data, valid in the read cycle |
| mem_busy_o | output | 1 | Sequence in progress |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_flags_o | output | 8 | Flag byte from the last sequence |
| rd_count_o | output | CNT_W | Read counter |
| wr_count_o | output | CNT_W | Write counter |

## Verification
The bench builds the block with a 4-bit address and 4-bit counters. The narrow counters wrap after sixteen sequences, so the R10 wrap is reached within a short run. The narrow address lets a 16-entry memory model cover every location. The flag layout stays at its default, and every op code is applied with both carry-in values and both settings of the update select. Operands include the all-zero, all-one, single-bit-7 and single-bit-0 patterns that exercise the zero, sign and carry edges.

// File: rtl/rotsh_pkg.sv
package rotsh_pkg;

  localparam int RS_DW = 8;

  typedef enum logic [2:0] {
    OP_RLC  = 3'd0,
    OP_RRC  = 3'd1,
    OP_RL   = 3'd2,
    OP_RR   = 3'd3,
    OP_SLA  = 3'd4,
    OP_SRA  = 3'd5,
    OP_SRL  = 3'd6,
    OP_PASS = 3'd7
  } rs_op_e;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_READ  = 2'd1,
    RS_WRITE = 2'd2,
    RS_DONE  = 2'd3
  } rs_state_e;

  typedef struct packed {
    logic [RS_DW-1:0] data;
    logic             cy;
  } rs_shift_t;

  // One-bit rotate/shift: result and outgoing bit
  function automatic rs_shift_t rs_shift(rs_op_e op, logic [RS_DW-1:0] d, logic cin);
    rs_shift_t r;
    unique case (op)
      OP_RLC:  r = '{data: {d[RS_DW-2:0], d[RS_DW-1]}, cy: d[RS_DW-1]};
      OP_RRC:  r = '{data: {d[0], d[RS_DW-1:1]},       cy: d[0]};
      OP_RL:   r = '{data: {d[RS_DW-2:0], cin},        cy: d[RS_DW-1]};
      OP_RR:   r = '{data: {cin, d[RS_DW-1:1]},        cy: d[0]};
      OP_SLA:  r = '{data: {d[RS_DW-2:0], 1'b0},       cy: d[RS_DW-1]};
      OP_SRA:  r = '{data: {d[RS_DW-1], d[RS_DW-1:1]}, cy: d[0]};
      OP_SRL:  r = '{data: {1'b0, d[RS_DW-1:1]},       cy: d[0]};
      default: r = '{data: d,                          cy: 1'b0};
    endcase
    return r;
  endfunction

  // Even parity: 1 when the number of ones is even
  function automatic logic rs_even_parity(logic [RS_DW-1:0] d);
    return ~(^d);
  endfunction

endpackage

// File: rtl/rotsh_shifter.sv
module rotsh_shifter
  import rotsh_pkg::*;
(
  input  logic [2:0]       op_i,
  input  logic [RS_DW-1:0] data_i,
  input  logic             cin_i,
  output logic [RS_DW-1:0] data_o,
  output logic             cout_o
);
  rs_shift_t sh;

  always_comb begin
    sh     = rs_shift(rs_op_e'(op_i), data_i, cin_i);
    data_o = sh.data;
    cout_o = sh.cy;
  end
endmodule

// File: rtl/rotsh_flagmerge.sv
module rotsh_flagmerge
  import rotsh_pkg::*;
#(
  parameter int S_BIT = 7,
  parameter int Z_BIT = 6,
  parameter int H_BIT = 4,
  parameter int P_BIT = 2,
  parameter int N_BIT = 1,
  parameter int C_BIT = 0
) (
  input  logic [7:0]       flags_i,
  input  logic [RS_DW-1:0] res_i,
  input  logic             cout_i,
  input  logic             szp_i,
  output logic [7:0]       flags_o
);
  always_comb begin
    flags_o        = flags_i;
    flags_o[H_BIT] = 1'b0;
    flags_o[N_BIT] = 1'b0;
    flags_o[C_BIT] = cout_i;
    if (szp_i) begin
      flags_o[S_BIT] = res_i[RS_DW-1];
      flags_o[Z_BIT] = (res_i == '0);
      flags_o[P_BIT] = rs_even_parity(res_i);
    end
  end
endmodule

// File: rtl/rotsh_unit.sv
module rotsh_unit
  import rotsh_pkg::*;
#(
  parameter int S_BIT = 7,
  parameter int Z_BIT = 6,
  parameter int H_BIT = 4,
  parameter int P_BIT = 2,
  parameter int N_BIT = 1,
  parameter int C_BIT = 0
) (
  input  logic [2:0]       op_i,
  input  logic [RS_DW-1:0] data_i,
  input  logic [7:0]       flags_i,
  input  logic             szp_i,
  output logic [RS_DW-1:0] data_o,
  output logic [7:0]       flags_o
);
  logic cout;

  rotsh_shifter u_sh (
    .op_i   (op_i),
    .data_i (data_i),
    .cin_i  (flags_i[C_BIT]),
    .data_o (data_o),
    .cout_o (cout)
  );

  rotsh_flagmerge #(
    .S_BIT(S_BIT), .Z_BIT(Z_BIT), .H_BIT(H_BIT),
    .P_BIT(P_BIT), .N_BIT(N_BIT), .C_BIT(C_BIT)
  ) u_fm (
    .flags_i (flags_i),
    .res_i   (data_o),
    .cout_i  (cout),
    .szp_i   (szp_i),
    .flags_o (flags_o)
  );
endmodule

// File: rtl/rotsh_rmw_ctrl.sv
module rotsh_rmw_ctrl
  import rotsh_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [7:0]       flags_i,
  input  logic [RS_DW-1:0] rdata_i,
  input  logic [RS_DW-1:0] calc_res_i,
  input  logic [7:0]       calc_flags_i,
  output logic [2:0]       calc_op_o,
  output logic [RS_DW-1:0] calc_data_o,
  output logic [7:0]       calc_flags_o,
  output logic             busy_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             done_o,
  output logic [AW-1:0]    addr_o,
  output logic [RS_DW-1:0] wdata_o,
  output logic [7:0]       flags_o,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic [CNT_W-1:0] wr_cnt_o
);
  rs_state_e state, state_nx;

  // named events
  logic take_ev, rd_fire, wr_fire;
  assign take_ev = start_i && (state == RS_IDLE);
  assign rd_fire = (state == RS_READ);
  assign wr_fire = (state == RS_WRITE);

  always_comb begin
    unique case (state)
      RS_IDLE:  state_nx = start_i ? RS_READ : RS_IDLE;
      RS_READ:  state_nx = RS_WRITE;
      RS_WRITE: state_nx = RS_DONE;
      default:  state_nx = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= RS_IDLE;
      calc_op_o    <= '0;
      addr_o       <= '0;
      calc_flags_o <= '0;
      calc_data_o  <= '0;
      flags_o      <= '0;
      rd_cnt_o     <= '0;
      wr_cnt_o     <= '0;
    end else begin
      state <= state_nx;
      if (take_ev) begin
        calc_op_o    <= op_i;
        addr_o       <= addr_i;
        calc_flags_o <= flags_i;
      end
      if (rd_fire) begin
        calc_data_o <= rdata_i;
        rd_cnt_o    <= rd_cnt_o + CNT_W'(1);
      end
      if (wr_fire) begin
        flags_o  <= calc_flags_i;
        wr_cnt_o <= wr_cnt_o + CNT_W'(1);
      end
    end
  end

  assign busy_o  = (state != RS_IDLE);
  assign rd_o    = rd_fire;
  assign wr_o    = wr_fire;
  assign done_o  = (state == RS_DONE);
  assign wdata_o = calc_res_i;
endmodule

// File: rtl/rotsh_top.sv
module rotsh_top
  import rotsh_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CNT_W = 16,
  parameter int S_BIT = 7,
  parameter int Z_BIT = 6,
  parameter int H_BIT = 4,
  parameter int P_BIT = 2,
  parameter int N_BIT = 1,
  parameter int C_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       acc_data_i,
  input  logic [2:0]       acc_op_i,
  input  logic [7:0]       acc_flags_i,
  input  logic             acc_szp_i,
  output logic [7:0]       acc_data_o,
  output logic [7:0]       acc_flags_o,
  input  logic             mem_start_i,
  input  logic [2:0]       mem_op_i,
  input  logic [AW-1:0]    mem_addr_i,
  input  logic [7:0]       mem_flags_i,
  input  logic [7:0]       mem_rdata_i,
  output logic             mem_busy_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             mem_done_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  output logic [7:0]       mem_flags_o,
  output logic [CNT_W-1:0] rd_count_o,
  output logic [CNT_W-1:0] wr_count_o
);
  logic [2:0]       m_op;
  logic [RS_DW-1:0] m_data, m_res;
  logic [7:0]       m_fin, m_fout;

  rotsh_unit #(
    .S_BIT(S_BIT), .Z_BIT(Z_BIT), .H_BIT(H_BIT),
    .P_BIT(P_BIT), .N_BIT(N_BIT), .C_BIT(C_BIT)
  ) u_acc (
    .op_i    (acc_op_i),
    .data_i  (acc_data_i),
    .flags_i (acc_flags_i),
    .szp_i   (acc_szp_i),
    .data_o  (acc_data_o),
    .flags_o (acc_flags_o)
  );

  rotsh_unit #(
    .S_BIT(S_BIT), .Z_BIT(Z_BIT), .H_BIT(H_BIT),
    .P_BIT(P_BIT), .N_BIT(N_BIT), .C_BIT(C_BIT)
  ) u_mem (
    .op_i    (m_op),
    .data_i  (m_data),
    .flags_i (m_fin),
    .szp_i   (1'b1),
    .data_o  (m_res),
    .flags_o (m_fout)
  );

  rotsh_rmw_ctrl #(.AW(AW), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (mem_start_i),
    .op_i         (mem_op_i),
    .addr_i       (mem_addr_i),
    .flags_i      (mem_flags_i),
    .rdata_i      (mem_rdata_i),
    .calc_res_i   (m_res),
    .calc_flags_i (m_fout),
    .calc_op_o    (m_op),
    .calc_data_o  (m_data),
    .calc_flags_o (m_fin),
    .busy_o       (mem_busy_o),
    .rd_o         (mem_rd_o),
    .wr_o         (mem_wr_o),
    .done_o       (mem_done_o),
    .addr_o       (mem_addr_o),
    .wdata_o      (mem_wdata_o),
    .flags_o      (mem_flags_o),
    .rd_cnt_o     (rd_count_o),
    .wr_cnt_o     (wr_count_o)
  );
endmodule

// File: rtl/rotsh_chk.sv
module rotsh_chk #(
  parameter int AW    = 8,
  parameter int CNT_W = 16,
  parameter int S_BIT = 7,
  parameter int Z_BIT = 6,
  parameter int H_BIT = 4,
  parameter int P_BIT = 2,
  parameter int N_BIT = 1,
  parameter int C_BIT = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       acc_data_i,
  input logic [2:0]       acc_op_i,
  input logic [7:0]       acc_flags_i,
  input logic             acc_szp_i,
  input logic [7:0]       acc_data_o,
  input logic [7:0]       acc_flags_o,
  input logic             mem_start_i,
  input logic             mem_busy_o,
  input logic             mem_rd_o,
  input logic             mem_wr_o,
  input logic             mem_done_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic [7:0]       mem_wdata_o,
  input logic [7:0]       mem_flags_o,
  input logic [CNT_W-1:0] rd_count_o,
  input logic [CNT_W-1:0] wr_count_o
);
  AST_RLC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_op_i == 3'd0) |-> (acc_data_o[0] == acc_data_i[7] && acc_flags_o[C_BIT] == acc_data_i[7])); // R1
  AST_RR_CARRY_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_op_i == 3'd3) |-> (acc_data_o[7] == acc_flags_i[C_BIT])); // R2
  AST_SRA_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_op_i == 3'd5) |-> (acc_data_o[7] == acc_data_i[7])); // R4
  AST_HN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_flags_o[H_BIT] == 1'b0 && acc_flags_o[N_BIT] == 1'b0)); // R6
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    acc_szp_i |-> (acc_flags_o[Z_BIT] == (acc_data_o == 8'h00))); // R7
  AST_SZP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_szp_i |-> (acc_flags_o[S_BIT] == acc_flags_i[S_BIT] && acc_flags_o[Z_BIT] == acc_flags_i[Z_BIT]
                    && acc_flags_o[P_BIT] == acc_flags_i[P_BIT])); // R8
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> (mem_wr_o && $stable(mem_addr_o))); // R9
  AST_WR_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |=> (mem_done_o && mem_flags_o[Z_BIT] == ($past(mem_wdata_o) == 8'h00))); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_o, mem_wr_o, mem_done_o})); // R9
  AST_RD_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> (rd_count_o == $past(rd_count_o) + CNT_W'(1))); // R10
  AST_WR_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_o |=> $stable(wr_count_o)); // R10
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_start_i && mem_done_o) |=> !mem_busy_o); // R11
endmodule

bind rotsh_top rotsh_chk #(
  .AW(AW), .CNT_W(CNT_W), .S_BIT(S_BIT), .Z_BIT(Z_BIT),
  .H_BIT(H_BIT), .P_BIT(P_BIT), .N_BIT(N_BIT), .C_BIT(C_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_data_i  (acc_data_i),
  .acc_op_i    (acc_op_i),
  .acc_flags_i (acc_flags_i),
  .acc_szp_i   (acc_szp_i),
  .acc_data_o  (acc_data_o),
  .acc_flags_o (acc_flags_o),
  .mem_start_i (mem_start_i),
  .mem_busy_o  (mem_busy_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_done_o  (mem_done_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_flags_o (mem_flags_o),
  .rd_count_o  (rd_count_o),
  .wr_count_o  (wr_count_o)
);

// File: tb/sim_rotsh_top.sv
`timescale 1ns/1ps
module sim_rotsh_top;
  localparam int AW = 4;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]    acc_data_i = '0, acc_flags_i = '0;
  logic [2:0]    acc_op_i = '0;
  logic          acc_szp_i = 1'b0;
  logic [7:0]    acc_data_o, acc_flags_o;
  logic          mem_start_i = 1'b0;
  logic [2:0]    mem_op_i = '0;
  logic [AW-1:0] mem_addr_i = '0;
  logic [7:0]    mem_flags_i = '0;
  logic [7:0]    mem_rdata_i;
  logic          mem_busy_o, mem_rd_o, mem_wr_o, mem_done_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_wdata_o, mem_flags_o;
  logic [CW-1:0] rd_count_o, wr_count_o;

  rotsh_top #(.AW(AW), .CNT_W(CW)) u0 (.*);

  // bench memory
  logic [7:0] mem [16];
  assign mem_rdata_i = mem[mem_addr_o];
  always @(posedge clk) if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;

  int vectors = 0, miscompares = 0;

  // reference model state
  int          ph = 0;
  int          m_op = 0, m_addr = 0, m_data = 0;
  logic [7:0]  m_fin = '0, exp_mflags = '0;
  int          exp_rd = 0, exp_wr = 0;
  int          exp_mem [16];

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic ref_op(input int op, input int d, input logic [7:0] fin, input bit upd,
                        output int res, output logic [7:0] fout);
    int cin, cout, ones;
    cin = fin[0];
    case (op)
      0: begin cout = d / 128; res = (d * 2) % 256 + cout; end
      1: begin cout = d % 2;   res = d / 2 + cout * 128; end
      2: begin cout = d / 128; res = (d * 2) % 256 + cin; end
      3: begin cout = d % 2;   res = d / 2 + cin * 128; end
      4: begin cout = d / 128; res = (d * 2) % 256; end
      5: begin cout = d % 2;   res = d / 2 + (d / 128) * 128; end
      6: begin cout = d % 2;   res = d / 2; end
      default: begin cout = 0; res = d; end
    endcase
    ones = 0;
    for (int k = 0; k < 8; k++) ones += (res >> k) & 1;
    fout = fin;
    fout[4] = 1'b0;
    fout[1] = 1'b0;
    fout[0] = (cout != 0);
    if (upd) begin
      fout[7] = (res >= 128);
      fout[6] = (res == 0);
      fout[2] = (ones % 2 == 0);
    end
  endtask

  function automatic string optag(int op);
    case (op)
      0, 1:    return "R1";
      2, 3:    return "R2";
      4, 6:    return "R3";
      5:       return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic model_step();
    int r;
    logic [7:0] f;
    case (ph)
      0: if (mem_start_i) begin
           m_op = mem_op_i; m_addr = mem_addr_i; m_fin = mem_flags_i; ph = 1;
         end
      1: begin m_data = exp_mem[m_addr]; exp_rd = (exp_rd + 1) % 16; ph = 2; end
      2: begin
           ref_op(m_op, m_data, m_fin, 1'b1, r, f);
           exp_mem[m_addr] = r; exp_mflags = f; exp_wr = (exp_wr + 1) % 16; ph = 3;
         end
      default: ph = 0;
    endcase
  endtask

  task automatic compare_all();
    int r;
    logic [7:0] f;
    string st;
    ref_op(acc_op_i, acc_data_i, acc_flags_i, acc_szp_i, r, f);
    chk(optag(acc_op_i), "acc result", acc_data_o, r);
    chk("R6", "acc H/N/C/pass bits", acc_flags_o & 8'h3B, f & 8'h3B);
    chk(acc_szp_i ? "R7" : "R8", "acc S/Z/P", acc_flags_o & 8'hC4, f & 8'hC4);
    st = (mem_start_i && ph != 0) ? "R11" : "R9";
    chk(st, "busy/rd/wr/done", {mem_busy_o, mem_rd_o, mem_wr_o, mem_done_o},
        {ph != 0, ph == 1, ph == 2, ph == 3});
    if (ph == 1 || ph == 2) chk("R9", "address", mem_addr_o, m_addr);
    if (ph == 2) begin
      ref_op(m_op, m_data, m_fin, 1'b1, r, f);
      chk(optag(m_op), "write data", mem_wdata_o, r);
    end
    chk("R9", "mem flags", mem_flags_o, exp_mflags);
    chk("R10", "read count", rd_count_o, exp_rd);
    chk("R10", "write count", wr_count_o, exp_wr);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic mem_op(int op, int addr, logic [7:0] fl, bit hold);
    mem_op_i = op[2:0]; mem_addr_i = addr[AW-1:0]; mem_flags_i = fl;
    mem_start_i = 1'b1;
    tick();
    if (!hold) mem_start_i = 1'b0;
    tick();
    tick();
    mem_start_i = 1'b0;
    tick();
  endtask

  int lfsr = 32'h1d;
  function automatic int nxt(int s);
    return (s >> 1) ^ ((s & 1) ? 32'hB8 : 0);
  endfunction

  initial begin
    int pats [6] = '{8'h80, 8'h01, 8'h00, 8'hFF, 8'hA5, 8'h5A};
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'((i * 37 + 5) % 256);
      exp_mem[i] = (i * 37 + 5) % 256;
    end
    @(negedge clk);
    @(negedge clk);
    // R12 reset state
    chk("R12", "idle strobes", {mem_busy_o, mem_rd_o, mem_wr_o, mem_done_o}, 0);
    chk("R12", "counters", {rd_count_o, wr_count_o}, 0);
    chk("R12", "mem flags", mem_flags_o, 0);
    rst_n = 1'b1;
    // accumulator path: every op, pattern, carry-in and update select
    for (int op = 0; op < 8; op++)
      for (int p = 0; p < 6; p++)
        for (int c = 0; c < 4; c++) begin
          acc_op_i = op[2:0];
          acc_data_i = pats[p][7:0];
          acc_flags_i = (c[0] ? 8'h29 : 8'hD6) ^ {c[1], 7'b0};
          acc_szp_i = c[1];
          tick();
        end
    // memory read-modify-write; 20 sequences wrap the 4-bit counters
    for (int n = 0; n < 20; n++) begin
      lfsr = nxt(lfsr);
      acc_op_i = lfsr[2:0]; acc_data_i = lfsr[7:0]; acc_szp_i = lfsr[3];
      acc_flags_i = {lfsr[4:0], lfsr[7:5]};
      mem_op(n % 8, (n * 5) % 16, (n % 2) ? 8'hFF : 8'h00, (n % 3) == 0);
    end
    // back-to-back start, then read back locations through another pass
    mem_start_i = 1'b1; mem_op_i = 3'd7; mem_addr_i = '0;
    repeat (8) tick();
    mem_start_i = 1'b0;
    tick();
    for (int a = 0; a < 16; a++) mem_op(7, a, 8'h00, 1'b0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R9 watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule